// File: doc/BRIEF.md
# Serial-Clocked Program Memory Access Port

This block sits between an external programming station and an on-chip byte-wide program store of 8064 locations (0 to 8063, 1F7Fh). The station has no address pins. It selects an operation on a 4-bit mode input and steps through the store by pulsing a single step pin. An internal address counter is cleared by one mode code. It then advances by one location for every four rising edges seen on the step pin.

Each byte moves as two nibbles on two 4-bit ports, one carrying bits 3:0 and the other bits 7:4. In the write operation the block samples the two ports and writes the byte at the current address. In the verify operation it turns both ports around and drives the stored byte on them. Towards the store the block presents a plain synchronous port: address, write data, write strobe, read enable, and read data that returns one clock after the read enable.

All inputs from the station are sampled on the block clock. The step pin passes through a synchronizer before its rising edges are counted.

Top module: `serprom_if`

## Requirements
- R1: After reset the address output is 0, both port output enables are low, and the write strobe and read enable are low.
- R2: mode_i[3:0] is decoded with bit 3 first: 4'b0101 selects clear, 4'b1110 selects write, 4'b1100 selects verify, and 4'b11?1 (bit 1 don't-care) selects inhibit. Every other code behaves as inhibit.
- R3: The clear mode sets the address and the step-pulse count to 0.
- R4: Outside clear mode, every fourth synchronized rising edge of step_i adds 1 to the address, and the other edges leave it unchanged. Edges seen while in clear mode are not counted.
- R5: Data bit positions are fixed: port A (dlo) carries bits 3:0 of the byte and port B (dhi) carries bits 7:4.
- R6: In verify mode both output enables are high, and the ports drive the byte stored at the current address. When the address steps, the ports follow to the new location.
- R7: The output enables are low in every mode other than verify.
- R8: In write mode the block asserts the write strobe with {dhi_i, dlo_i} as data at the current address. In any other mode it writes nothing.
- R9: The address stops at 8063 and does not wrap when further steps arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Operation select, bit 3 first |
| step_i | input | 1 | Address step pin from the programming station |
| dlo_i | input | 4 | Port A input, data bits 3:0 |
| dhi_i | input | 4 | Port B input, data bits 7:4 |
| dlo_o | output | 4 | Port A output value |
| dhi_o | output | 4 | Port B output value |
| dlo_oe_o | output | 1 | Port A output enable |
| dhi_oe_o | output | 1 | Port B output enable |
| mem_addr_o | output | 13 | Store address |
| mem_wdata_o | output | 8 | Store write data |
| mem_we_o | output | 1 | Store write strobe |
| mem_re_o | output | 1 | Store read enable |
| mem_rdata_i | input | 8 | Store read data, valid one clock after read enable |

## Verification
The assertions assume that the station holds each level of step_i for at least two block clocks. They also assume that the mode and data inputs stay steady while a step is in flight, and that the store returns read data exactly one clock after mem_re_o. The bench changes inputs only on falling clock edges and holds each step-pin level for two clocks. It leaves several clocks between a mode change and the check that follows, so the synchronizer and the read latency have settled. Its store model writes on the strobe and returns data one clock after the read enable, which matches the contract the block expects.

// File: rtl/serprom_pkg.sv
package serprom_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned BYTE_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    OP_INHIBIT = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_WRITE   = 2'd2,
    OP_VERIFY  = 2'd3
  } op_e;

  // codes listed bit 3 first; bit 1 of the inhibit code is don't-care
  localparam logic [3:0] CODE_CLEAR  = 4'b0101;
  localparam logic [3:0] CODE_WRITE  = 4'b1110;
  localparam logic [3:0] CODE_VERIFY = 4'b1100;
endpackage

// File: rtl/serprom_pin_sync.sv
module serprom_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= 1'b0;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/serprom_mode_dec.sv
module serprom_mode_dec
  import serprom_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] mode_i,
  output op_e        op_o
);
  logic [3:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 4'b1111;
    else         mode_q <= mode_i;
  end

  always_comb begin
    unique case (mode_q)
      CODE_CLEAR:  op_o = OP_CLEAR;
      CODE_WRITE:  op_o = OP_WRITE;
      CODE_VERIFY: op_o = OP_VERIFY;
      default:     op_o = OP_INHIBIT;
    endcase
  end

  AST_INHIBIT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[3:2] == 2'b11 && mode_i[0]) |=> op_o == OP_INHIBIT); // R2
endmodule

// File: rtl/serprom_addr_ctr.sv
module serprom_addr_ctr #(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned LAST_ADDR = 8063,
  parameter int unsigned PULSES    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned CNT_W = (PULSES > 1) ? $clog2(PULSES) : 1;
  localparam logic [CNT_W-1:0]  CNT_TOP = CNT_W'(PULSES - 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(LAST_ADDR);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wrap;

  assign wrap = (cnt_q == CNT_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (step_i) begin
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      if (wrap && addr_q != ADDR_TOP) addr_q <= addr_q + ADDR_W'(1);
    end
  end

  assign addr_o = addr_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> addr_o == '0); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o <= ADDR_TOP); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !step_i) |=> $stable(addr_o)); // R4
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && step_i && addr_o != ADDR_TOP) |=>
      (addr_o == $past(addr_o) || addr_o == $past(addr_o) + ADDR_W'(1))); // R4
endmodule

// File: rtl/serprom_if.sv
module serprom_if
  import serprom_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned LAST_ADDR   = 8063,
  parameter int unsigned PULSES      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        mode_i,
  input  logic              step_i,
  input  logic [NIB_W-1:0]  dlo_i,
  input  logic [NIB_W-1:0]  dhi_i,
  output logic [NIB_W-1:0]  dlo_o,
  output logic [NIB_W-1:0]  dhi_o,
  output logic              dlo_oe_o,
  output logic              dhi_oe_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [BYTE_W-1:0] mem_rdata_i
);
  op_e               op;
  logic              step_rise;
  logic [BYTE_W-1:0] din_q;
  logic              drive_q;

  serprom_mode_dec u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .op_o   (op)
  );

  serprom_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (step_i),
    .rise_o (step_rise)
  );

  serprom_addr_ctr #(
    .ADDR_W    (ADDR_W),
    .LAST_ADDR (LAST_ADDR),
    .PULSES    (PULSES)
  ) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (op == OP_CLEAR),
    .step_i (step_rise),
    .addr_o (mem_addr_o)
  );

  // sample data alongside the mode so both line up in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) din_q <= '0;
    else         din_q <= {dhi_i, dlo_i};
  end

  // read data lags the enable by one clock; enable the drivers to match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_q <= 1'b0;
    else         drive_q <= (op == OP_VERIFY);
  end

  assign mem_we_o    = (op == OP_WRITE);
  assign mem_re_o    = (op == OP_VERIFY);
  assign mem_wdata_o = din_q;

  assign dlo_oe_o = drive_q;
  assign dhi_oe_o = drive_q;
  assign dlo_o    = drive_q ? mem_rdata_i[NIB_W-1:0]      : '0;
  assign dhi_o    = drive_q ? mem_rdata_i[BYTE_W-1:NIB_W] : '0;

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !dlo_oe_o); // R7
  AST_DRIVE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlo_oe_o |-> $past(mem_re_o)); // R6
  AST_WRITE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != CODE_WRITE) |=> !mem_we_o); // R8
endmodule

// File: tb/serprom_if_tb.sv
module serprom_if_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode = 4'b1111;
  logic       step = 1'b0;
  logic [3:0] dlo = '0, dhi = '0;
  logic [3:0] dlo_o, dhi_o;
  logic       dlo_oe, dhi_oe;
  logic [12:0] maddr;
  logic [7:0] mwdata, mrdata;
  logic       mwe, mre;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] store [8064];

  localparam logic [3:0] M_CLR = 4'b0101, M_WR = 4'b1110,
                         M_VF = 4'b1100, M_INH = 4'b1101, M_INH2 = 4'b1111;

  always #4 clk = ~clk;

  serprom_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .step_i(step),
    .dlo_i(dlo), .dhi_i(dhi), .dlo_o(dlo_o), .dhi_o(dhi_o),
    .dlo_oe_o(dlo_oe), .dhi_oe_o(dhi_oe), .mem_addr_o(maddr),
    .mem_wdata_o(mwdata), .mem_we_o(mwe), .mem_re_o(mre),
    .mem_rdata_i(mrdata)
  );

  initial for (int i = 0; i < 8064; i++) store[i] = 8'hFF;

  always_ff @(posedge clk) begin
    if (mwe) store[maddr] <= mwdata;
    if (mre) mrdata <= store[maddr];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run exceeded cycle limit");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk); mode = m; idle(4);
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); step = 1'b1;
      idle(2); step = 1'b0; idle(1);
    end
    idle(3);
  endtask

  task automatic t_reset;
    idle(1);
    chk(maddr == 0, "R1 addr", maddr, 0);
    chk(!dlo_oe && !dhi_oe, "R1 oe", {dlo_oe, dhi_oe}, 0);
    chk(!mwe && !mre, "R1 strobes", {mwe, mre}, 0);
  endtask

  task automatic t_write_verify;
    logic [7:0] pats [4] = '{8'h5A, 8'hC3, 8'h0F, 8'h81};
    set_mode(M_CLR);
    set_mode(M_INH);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); dlo = pats[i][3:0]; dhi = pats[i][7:4];
      set_mode(M_WR);
      chk(mwe, "R8 strobe in write", mwe, 1);
      chk(mwdata == pats[i], "R5 write nibbles", mwdata, pats[i]);
      chk(!dlo_oe && !dhi_oe, "R7 no drive in write", dlo_oe, 0);
      set_mode(M_INH);
      pulse(4);
    end
    chk(maddr == 4, "R4 four steps", maddr, 4);
    set_mode(M_CLR);
    chk(maddr == 0, "R3 clear", maddr, 0);
    set_mode(M_VF);
    for (int i = 0; i < 4; i++) begin
      chk(dlo_oe && dhi_oe, "R6 oe in verify", {dlo_oe, dhi_oe}, 3);
      chk(dlo_o == pats[i][3:0], "R5 low nibble", dlo_o, pats[i][3:0]);
      chk(dhi_o == pats[i][7:4], "R6 high nibble", dhi_o, pats[i][7:4]);
      pulse(4);
    end
    chk(!mwe, "R8 no write in verify", mwe, 0);
  endtask

  task automatic t_inhibit;
    set_mode(M_INH);
    @(negedge clk); dlo = 4'h7; dhi = 4'h3;
    set_mode(M_INH2);
    chk(!mwe, "R2 inhibit x-bit", mwe, 0);
    chk(!dlo_oe, "R7 inhibit no drive", dlo_oe, 0);
    set_mode(4'b0000);
    chk(!mwe && !mre, "R2 unknown code idle", {mwe, mre}, 0);
    set_mode(M_VF);
    chk(maddr == 4 && dlo_o == 4'hF && dhi_o == 4'hF, "R8 untouched cell",
        {dhi_o, dlo_o}, 8'hFF);
  endtask

  task automatic t_step_count;
    set_mode(M_CLR);
    set_mode(M_INH);
    pulse(3);
    chk(maddr == 0, "R4 three edges hold", maddr, 0);
    pulse(1);
    chk(maddr == 1, "R4 fourth edge steps", maddr, 1);
    pulse(2);
    set_mode(M_CLR);
    pulse(3);
    chk(maddr == 0, "R3 edges in clear ignored", maddr, 0);
    set_mode(M_INH);
    pulse(3);
    chk(maddr == 0, "R3 pulse count cleared", maddr, 0);
    pulse(1);
    chk(maddr == 1, "R4 step after clear", maddr, 1);
  endtask

  task automatic t_saturate;
    set_mode(M_CLR);
    set_mode(M_INH);
    for (int k = 0; k < 8063 * 4; k++) begin
      @(negedge clk); step = 1'b1;
      @(negedge clk); @(negedge clk); step = 1'b0;
      @(negedge clk);
    end
    idle(4);
    chk(maddr == 8063, "R9 reach last", maddr, 8063);
    pulse(8);
    chk(maddr == 8063, "R9 no wrap", maddr, 8063);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_write_verify();
    t_inhibit();
    t_step_count();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule